// File: doc/BRIEF.md
# Register-Indirect Exchange Branch Unit

This block holds the program counter and the compact-mode flag of a 32-bit CPU core that runs either 32-bit instructions or 16-bit compact instructions. On each issued instruction it either takes a register-indirect branch that may switch the instruction set, or steps the program counter past the instruction. The step is 2 bytes in compact mode and 4 bytes in full mode. The condition check is done elsewhere and arrives as a single pass bit. The block detects the exchange branch itself from the instruction word. A second encoding, meant for an extended execution state that this core does not have, is treated as the same plain exchange branch.

The block also serves the rest of the pipeline in two ways. First, it gives the view of the program counter that an instruction sees when it names register 15 as an operand. There is a data form with bit 0 masked and an address form with bits 1:0 masked. Both are offset ahead by two instruction sizes. Second, it selects the 16-bit compact instruction from a fetched 32-bit word using bit 1 of the program counter. A sticky warning flag records any branch that used register 15 as its target.

Top module: `bx_pc_unit`

## Requirements
- R1: While rst_n is low, pc, thumb and r15_warn are all 0 on the next clock edge.
- R2: An exchange branch executes when issue is 1, instr[27:8] is 0x12FFF, instr[7:4] is 0x1, and either instr[31:28] is 0xE or cond_pass is 1. One cycle later, thumb equals bit 0 of the target value and pc equals the target value with bit 0 cleared.
- R3: When issue is 1 with an exchange encoding, instr[31:28] is not 0xE and cond_pass is 0, pc advances by 2 if thumb is 1 and by 4 otherwise. thumb is unchanged.
- R4: The encoding with instr[7:4] equal to 0x2 (the rest as in R2) behaves exactly like the exchange branch of R2 and R3.
- R5: An issued instruction that is not an exchange encoding advances pc by the instruction size and leaves thumb unchanged. With issue at 0, pc and thumb hold.
- R6: opnd_data equals (pc with bit 0 cleared) plus twice the instruction size when opnd_idx is 15. Otherwise it equals opnd_val.
- R7: opnd_addr equals (pc with bits 1:0 cleared) plus twice the instruction size when opnd_idx is 15. Otherwise it equals opnd_val.
- R8: thumb_half is fetch_word[31:16] when pc bit 1 is 1, and fetch_word[15:0] otherwise.
- R9: tgt_idx equals instr[3:0]. When the executing branch names index 15, the target value is the current pc rather than tgt_val, the branch is still taken, and r15_warn becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is executed this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check result from outside |
| tgt_idx | output | 4 | Register file read index for the branch target |
| tgt_val | input | 32 | Register file value at tgt_idx |
| opnd_idx | input | 4 | Operand register index being read |
| opnd_val | input | 32 | Stored value of that operand register |
| opnd_data | output | 32 | Operand value, data form |
| opnd_addr | output | 32 | Operand value, address form |
| fetch_word | input | 32 | Fetched 32-bit word |
| thumb_half | output | 16 | Selected compact instruction halfword |
| pc | output | 32 | Current program counter |
| thumb | output | 1 | Current compact-mode flag |
| r15_warn | output | 1 | Sticky flag for a branch through register 15 |

## Verification
The bench sends the always-execute code together with a cond_pass of 0. A design that ignored that code would step instead of branching. It also sends odd and even target values in both modes. A design that kept bit 0 in pc, or took thumb from the wrong bit, would lose the mode switch. The second exchange encoding and words that are almost exchange encodings are mixed in. A wrong decode then either drops the alias or branches on a plain instruction. Finally, the bench reads register 15 through both views in both modes and with pc bit 1 set. A wrong mask or offset, or a halfword chosen by the wrong bit, shows up as a wrong value in the same cycle.

// File: rtl/bx_pc_unit.sv
module bx_pc_unit #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [31:0]    instr,
  input  logic           cond_pass,
  output logic [3:0]     tgt_idx,
  input  logic [W-1:0]   tgt_val,
  input  logic [3:0]     opnd_idx,
  input  logic [W-1:0]   opnd_val,
  output logic [W-1:0]   opnd_data,
  output logic [W-1:0]   opnd_addr,
  input  logic [W-1:0]   fetch_word,
  output logic [W/2-1:0] thumb_half,
  output logic [W-1:0]   pc,
  output logic           thumb,
  output logic           r15_warn
);
  localparam logic [3:0]  COND_AL = 4'hE;
  localparam logic [3:0]  PC_IDX  = 4'hF;
  localparam logic [19:0] XCHG_HI = 20'h12FFF;

  logic [W-1:0] pc_q;
  logic         t_q, warn_q;

  wire [W-1:0] isz     = t_q ? W'(2) : W'(4);
  wire [W-1:0] ahead   = isz << 1;
  wire         is_xchg = (instr[27:8] == XCHG_HI) && (instr[7:4] == 4'h1 || instr[7:4] == 4'h2);
  wire         runs    = (instr[31:28] == COND_AL) || cond_pass;
  wire         rm_pc   = (instr[3:0] == PC_IDX);
  wire [W-1:0] tgt     = rm_pc ? pc_q : tgt_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      t_q    <= 1'b0;
      warn_q <= 1'b0;
    end else if (issue) begin
      if (is_xchg && runs) begin
        t_q  <= tgt[0];
        pc_q <= tgt & ~W'(1);
        if (rm_pc) warn_q <= 1'b1;
      end else begin
        pc_q <= pc_q + isz;
      end
    end
  end

  assign tgt_idx    = instr[3:0];
  assign opnd_data  = (opnd_idx == PC_IDX) ? (pc_q & ~W'(1)) + ahead : opnd_val;
  assign opnd_addr  = (opnd_idx == PC_IDX) ? (pc_q & ~W'(3)) + ahead : opnd_val;
  assign thumb_half = pc_q[1] ? fetch_word[W-1:W/2] : fetch_word[W/2-1:0];
  assign pc         = pc_q;
  assign thumb      = t_q;
  assign r15_warn   = warn_q;
endmodule

// File: rtl/bx_pc_unit_chk.sv
module bx_pc_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [31:0]  instr,
  input logic         cond_pass,
  input logic [3:0]   opnd_idx,
  input logic [W-1:0] opnd_addr,
  input logic [W-1:0] pc,
  input logic         thumb,
  input logic         r15_warn
);
  wire xchg = instr[27:8] == 20'h12FFF && (instr[7:4] == 4'h1 || instr[7:4] == 4'h2);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (pc == '0 && !thumb && !r15_warn));

  p_pc_even_r2: assert property (@(posedge clk) disable iff (!rst_n) pc[0] == 1'b0);

  p_fail_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && xchg && instr[31:28] != 4'hE && !cond_pass) |=>
      (pc == $past(pc) + ($past(thumb) ? W'(2) : W'(4)) && $stable(thumb)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(pc) && $stable(thumb)));

  p_addr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_idx == 4'hF) |-> (opnd_addr[1:0] == 2'b00));

  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    r15_warn |=> r15_warn);
endmodule

bind bx_pc_unit bx_pc_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .cond_pass(cond_pass),
  .opnd_idx(opnd_idx), .opnd_addr(opnd_addr), .pc(pc), .thumb(thumb), .r15_warn(r15_warn)
);

// File: tb/bx_pc_unit_tb_top.sv
module bx_pc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_pass = 1'b0;
  logic [3:0]  tgt_idx;
  logic [31:0] tgt_val = '0;
  logic [3:0]  opnd_idx = '0;
  logic [31:0] opnd_val = '0;
  logic [31:0] opnd_data, opnd_addr;
  logic [31:0] fetch_word = '0;
  logic [15:0] thumb_half;
  logic [31:0] pc;
  logic        thumb, r15_warn;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_pc;
  logic        m_t, m_warn;

  always #(CLK_PERIOD/2) clk = ~clk;

  bx_pc_unit #(.W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .cond_pass(cond_pass),
    .tgt_idx(tgt_idx), .tgt_val(tgt_val), .opnd_idx(opnd_idx), .opnd_val(opnd_val),
    .opnd_data(opnd_data), .opnd_addr(opnd_addr), .fetch_word(fetch_word),
    .thumb_half(thumb_half), .pc(pc), .thumb(thumb), .r15_warn(r15_warn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sz(input logic t);
    return t ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] exp_data(input logic [3:0] idx, input logic [31:0] v,
                                           input logic [31:0] p, input logic t);
    return (idx == 4'hF) ? ((p & ~32'd1) + 2 * sz(t)) : v;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [3:0] idx, input logic [31:0] v,
                                           input logic [31:0] p, input logic t);
    return (idx == 4'hF) ? ((p & ~32'd3) + 2 * sz(t)) : v;
  endfunction

  function automatic logic is_x(input logic [31:0] w);
    return w[27:8] == 20'h12FFF && (w[7:4] == 4'h1 || w[7:4] == 4'h2);
  endfunction

  task automatic model_step();
    logic [31:0] tv;
    if (!issue) return;
    if (is_x(instr) && (instr[31:28] == 4'hE || cond_pass)) begin
      tv = (instr[3:0] == 4'hF) ? m_pc : tgt_val;
      if (instr[3:0] == 4'hF) m_warn = 1'b1;
      m_t  = tv[0];
      m_pc = tv & ~32'd1;
    end else begin
      m_pc = m_pc + sz(m_t);
    end
  endtask

  task automatic step(input logic iss, input logic [31:0] w, input logic cp,
                      input logic [31:0] tv, input logic [3:0] oi, input logic [31:0] ov,
                      input logic [31:0] fw, input string req);
    @(negedge clk);
    issue = iss; instr = w; cond_pass = cp; tgt_val = tv;
    opnd_idx = oi; opnd_val = ov; fetch_word = fw;
    #1;
    chk("R9 tgt_idx", {28'd0, tgt_idx}, {28'd0, w[3:0]});
    chk("R6 opnd_data", opnd_data, exp_data(oi, ov, m_pc, m_t));
    chk("R7 opnd_addr", opnd_addr, exp_addr(oi, ov, m_pc, m_t));
    chk("R8 thumb_half", {16'd0, thumb_half}, {16'd0, m_pc[1] ? fw[31:16] : fw[15:0]});
    model_step();
    @(negedge clk);
    issue = 1'b0;
    chk({req, " pc"}, pc, m_pc);
    chk({req, " thumb"}, {31'd0, thumb}, {31'd0, m_t});
    chk("R9 warn", {31'd0, r15_warn}, {31'd0, m_warn});
  endtask

  function automatic logic [31:0] xw(input logic [3:0] c, input logic j, input logic [3:0] rm);
    return {c, 20'h12FFF, j ? 4'h2 : 4'h1, rm};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    m_pc = '0; m_t = 1'b0; m_warn = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 pc", pc, 32'd0);
    chk("R1 thumb", {31'd0, thumb}, 32'd0);
    chk("R1 warn", {31'd0, r15_warn}, 32'd0);
    rst_n = 1'b1;

    step(1'b1, 32'hE3A00000, 1'b1, 32'h0, 4'hF, 32'h0, 32'hAAAA5555, "R5 plain");
    step(1'b1, xw(4'hE, 1'b0, 4'd3), 1'b0, 32'h00001001, 4'hF, 32'h0, 32'h11112222, "R2 always");
    step(1'b1, 32'hE3A00000, 1'b0, 32'h0, 4'hF, 32'h0, 32'h33334444, "R5 thumb step");
    step(1'b1, xw(4'h1, 1'b0, 4'd2), 1'b0, 32'h00002000, 4'hF, 32'h0, 32'h55556666, "R3 fail thumb");
    step(1'b0, xw(4'hE, 1'b0, 4'd2), 1'b1, 32'h00004000, 4'hF, 32'h0, 32'h0, "R5 idle");
    step(1'b1, xw(4'h1, 1'b1, 4'd5), 1'b1, 32'h00008000, 4'h3, 32'hDEADBEEF, 32'h0, "R4 alias");
    step(1'b1, xw(4'h0, 1'b1, 4'd5), 1'b0, 32'h00000101, 4'hF, 32'h0, 32'h0, "R4 alias fail");
    step(1'b1, {4'hE, 20'h12FFF, 4'h3, 4'd1}, 1'b1, 32'h00000101, 4'hF, 32'h0, 32'h0, "R5 near encoding");
    step(1'b1, xw(4'hE, 1'b0, 4'hF), 1'b0, 32'h12345679, 4'hF, 32'h0, 32'h0, "R9 r15 target");
    step(1'b1, xw(4'hE, 1'b1, 4'd7), 1'b0, 32'h00000203, 4'hF, 32'h0, 32'hBEEFCAFE, "R4 to thumb");
    step(1'b1, 32'hE3A00000, 1'b0, 32'h0, 4'hF, 32'h0, 32'hCAFEF00D, "R8 pc bit1");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [3:0]  c;
      int          k;
      k = int'($urandom_range(0, 9));
      c = ($urandom_range(0, 2) == 0) ? 4'hE : 4'($urandom);
      if (k < 4)      w = xw(c, 1'b0, 4'($urandom));
      else if (k < 7) w = xw(c, 1'b1, 4'($urandom));
      else            w = $urandom;
      step(1'($urandom_range(0, 5) != 0), w, 1'($urandom), $urandom,
           ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom), $urandom, $urandom, "R2 R3 random");
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pc after run", pc, 32'd0);
    chk("R1 warn after run", {31'd0, r15_warn}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule